// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block receives fixed-length command words over a three-wire serial link: an active-low frame select, a serial clock and a serial data line. The whole block runs on one system clock. It passes the three pins through a synchronizer and finds serial clock edges by comparing samples, so it never uses the serial clock as a clock. While a frame is open, each falling edge of the serial clock shifts one data bit into the word. The most significant bit arrives first.

When the last bit of a word has been received, the block presents the word and raises a one-cycle valid strobe. It does this right away, without waiting for the select line to rise. It also reports whether the two reserved top bits were zero. Downstream control logic decodes the word. The top eight bits form the control byte and the low sixteen bits are the payload.

If the select line is released before the word is complete, the frame is aborted. The partial contents and the bit count are cleared, and nothing is presented. Once a word has been taken, further clock edges are ignored until the select line has been released and asserted again.

Top module: `serial_cmd_rx`

## Requirements
- R1: While reset is high and after it is released, `cmd_word_o` is 0, `cmd_valid_o` is 0 and `cmd_ok_o` is 1, until the first complete frame. A reset in the middle of a frame returns the outputs to these values.
- R2: While a frame is open, each falling edge of `sck_i` shifts in `sdi_i`. The first bit received lands in bit 23 of `cmd_word_o` and the 24th bit lands in bit 0.
- R3: `cmd_valid_o` is high for exactly one system clock cycle per completed frame. It rises while `sel_n_i` is still low, without waiting for select to be released.
- R4: If `sel_n_i` rises before the 24th falling edge, no valid strobe is produced and `cmd_word_o` and `cmd_ok_o` keep their previous values. The following frame is assembled from its own 24 bits only, so partial bits and the partial count do not carry over.
- R5: Falling `sck_i` edges after the 24th, while `sel_n_i` stays low, are ignored. No further strobe occurs until `sel_n_i` is raised and lowered again.
- R6: `cmd_ok_o` is 1 exactly when bits 23 and 22 of the presented word are both 0. Bit 19 and every other bit have no effect on it.
- R7: A frame opens only on a high-to-low transition of `sel_n_i`. If select is held low through the release of reset, no frame opens.
- R8: `sck_i` edges while `sel_n_i` is high produce no strobe and leave the outputs unchanged.
- R9: With the system clock at least four times the serial clock rate, `cmd_valid_o` is high no later than six system clock cycles after the 24th falling edge of `sck_i` at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low frame select pin (asynchronous) |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| sdi_i | input | 1 | Serial data pin (asynchronous) |
| cmd_word_o | output | 24 | Last completed command word |
| cmd_valid_o | output | 1 | One-cycle strobe marking a new word |
| cmd_ok_o | output | 1 | High when the reserved bits of the word are zero |

## Verification
Two situations are hard to reach from the ports. One is an abort that leaves a partial count behind, which is visible only if a later frame completes early. The other is completion while select stays low, after which extra clock edges must not start a second word. The stimulus covers both. It releases select after 10 and after 23 edges and then sends a full frame, checking that exactly one strobe arrives and that it carries the exact word. It also clocks 30 edges into a single frame, and then a further 24 edges with select still low. The latency check measures the gap between the last pin edge and the strobe in system clock cycles.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_HOLD  = 2'd2
  } frame_state_t;

  typedef struct packed {
    logic sel_n;
    logic sck;
    logic sdi;
  } pins_t;
endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx_edge.sv
module serial_cmd_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_s,
  input  logic sck_s,
  output logic sel_fall,
  output logic sck_fall
);
  logic sel_prev, sck_prev;

  // Previous select resets low so a line already low at reset is not a start.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      sel_prev <= sel_n_s;
      sck_prev <= sck_s;
    end
  end

  assign sel_fall = sel_prev & ~sel_n_s;
  assign sck_fall = sck_prev & ~sck_s;

  assert_sel_fall_start_R7: assert property (@(posedge clk) disable iff (rst)
    sel_fall |-> $past(sel_n_s) && !sel_n_s);
endmodule

// File: rtl/serial_cmd_rx_frame.sv
module serial_cmd_rx_frame
  import serial_cmd_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              sel_fall,
  input  logic              sck_fall,
  input  logic              sdi_s,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  frame_state_t      state;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shnext;

  assign shnext = {shreg[WORD_W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FR_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        FR_IDLE: begin
          if (sel_fall) begin
            state <= FR_SHIFT;
            cnt   <= '0;
            shreg <= '0;
          end
        end
        FR_SHIFT: begin
          if (sel_n_s) begin
            state <= FR_IDLE;
            cnt   <= '0;
            shreg <= '0;
          end else if (sck_fall) begin
            shreg <= shnext;
            if (cnt == LAST) begin
              done_o <= 1'b1;
              word_o <= shnext;
              state  <= FR_HOLD;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        FR_HOLD: begin
          if (sel_n_s) state <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assert_abort_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (state == FR_SHIFT && sel_n_s) |=> (state == FR_IDLE && cnt == '0));
  assert_unselected_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !done_o);
  assert_hold_ignores_R5: assert property (@(posedge clk) disable iff (rst)
    (state == FR_HOLD) |=> !done_o);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] RSVD_MASK = 24'hC0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_valid_o,
  output logic              cmd_ok_o
);
  pins_t pins_raw, pins_s;
  logic sel_fall, sck_fall;
  logic frame_done;
  logic [WORD_W-1:0] frame_word;

  assign pins_raw = '{sel_n: sel_n_i, sck: sck_i, sdi: sdi_i};

  serial_cmd_rx_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  serial_cmd_rx_edge u_edge (
    .clk(clk), .rst(rst), .sel_n_s(pins_s.sel_n), .sck_s(pins_s.sck),
    .sel_fall(sel_fall), .sck_fall(sck_fall)
  );

  serial_cmd_rx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst(rst), .sel_n_s(pins_s.sel_n), .sel_fall(sel_fall),
    .sck_fall(sck_fall), .sdi_s(pins_s.sdi),
    .done_o(frame_done), .word_o(frame_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_word_o  <= '0;
      cmd_valid_o <= 1'b0;
      cmd_ok_o    <= 1'b1;
    end else begin
      cmd_valid_o <= frame_done;
      if (frame_done) begin
        cmd_word_o <= frame_word;
        cmd_ok_o   <= ((frame_word & RSVD_MASK) == '0);
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cmd_word_o == '0 && !cmd_valid_o && cmd_ok_o));
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);
  assert_word_held_R4: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_o |-> ($stable(cmd_word_o) && $stable(cmd_ok_o)));
endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
  localparam int HALF = 5;
  localparam int NV   = 8;
  localparam logic [23:0] V_WORD [NV] = '{24'h12_3456, 24'h00_FFFF, 24'hC0_0001,
    24'h48_A5A5, 24'h08_0000, 24'hFF_FFFF, 24'h3F_0F0F, 24'h30_BEEF};
  localparam int V_BITS [NV] = '{24, 24, 24, 24, 24, 10, 23, 24};

  logic clk = 0, rst = 1, sel_n = 0, sck = 1, sdi = 0;
  logic [23:0] word;
  logic valid, ok;
  int checks = 0, fails = 0, pulses = 0, run = 0, maxrun = 0, cyc = 0;
  int last_vcyc = 0, fall_cyc = 0;
  bit finished = 0;
  logic [23:0] exp_word;
  logic exp_ok;

  always #4 clk = ~clk;

  serial_cmd_rx u_serial_cmd_rx (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
    .cmd_word_o(word), .cmd_valid_o(valid), .cmd_ok_o(ok)
  );

  always @(negedge clk) begin
    cyc++;
    if (valid) begin
      pulses++;
      run++;
      last_vcyc = cyc;
      if (run > maxrun) maxrun = run;
    end else run = 0;
  end

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Clock out nbits, MSB first; bits past 24 are sent as ones.
  task automatic send_bits(input logic [23:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b1;
      wt(HALF);
      sck = 0;
      fall_cyc = cyc;
      wt(HALF);
      sck = 1;
    end
  endtask

  task automatic open_frame();
    sel_n = 0;
    wt(4);
  endtask

  task automatic close_frame();
    wt(2);
    sel_n = 1;
    wt(6);
  endtask

  initial begin
    wt(200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    wt(3);
    chk(word == 0 && !valid && ok, "R1 reset state", {word, valid, ok}, {24'h0, 2'b01});
    rst = 0;
    wt(4);
    // R7: select held low through reset release opens no frame
    p0 = pulses;
    send_bits(24'hABCDEF, 24);
    wt(6);
    chk(pulses == p0, "R7 select low at reset", pulses - p0, 0);
    sel_n = 1;
    wt(6);
    exp_word = 24'h0;
    exp_ok = 1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      open_frame();
      send_bits(V_WORD[v], V_BITS[v]);
      if (V_BITS[v] == 24) begin
        chk(pulses == p0 + 1, "R3 strobe before select release", pulses - p0, 1);
        chk(last_vcyc - fall_cyc <= 6, "R9 latency", last_vcyc - fall_cyc, 6);
        exp_word = V_WORD[v];
        exp_ok = (V_WORD[v][23:22] == 2'b00);
      end
      close_frame();
      if (V_BITS[v] == 24) begin
        chk(word == exp_word, "R2 word order", word, exp_word);
        chk(ok == exp_ok, "R6 reserved flag", ok, exp_ok);
      end else begin
        chk(pulses == p0, "R4 abort no strobe", pulses - p0, 0);
        chk(word == exp_word && ok == exp_ok, "R4 abort keeps outputs", {word, ok}, {exp_word, exp_ok});
      end
    end
    chk(maxrun == 1, "R3 strobe width", maxrun, 1);

    // R4: partial count must not leak into next frame
    open_frame();
    send_bits(24'hFFFFFF, 10);
    close_frame();
    p0 = pulses;
    open_frame();
    send_bits(24'h15_AA55, 24);
    close_frame();
    chk(pulses == p0 + 1 && word == 24'h15_AA55, "R4 count cleared after abort", word, 24'h15AA55);

    // R5: extra edges after completion ignored
    p0 = pulses;
    open_frame();
    send_bits(24'h2C_3C3C, 30);
    wt(4);
    chk(pulses == p0 + 1, "R5 one strobe for long frame", pulses - p0, 1);
    chk(word == 24'h2C_3C3C, "R5 word from first 24 bits", word, 24'h2C3C3C);
    send_bits(24'h01_0203, 24);
    wt(6);
    chk(pulses == p0 + 1, "R5 no restart without reselect", pulses - p0, 1);
    close_frame();
    open_frame();
    send_bits(24'h01_0203, 24);
    close_frame();
    chk(pulses == p0 + 2 && word == 24'h01_0203, "R5 reselect resumes", word, 24'h010203);

    // R8: clocks with select high
    p0 = pulses;
    send_bits(24'h00_1111, 24);
    wt(6);
    chk(pulses == p0 && word == 24'h01_0203, "R8 unselected clocks", word, 24'h010203);

    // R6: bit 19 alone does not clear the flag
    open_frame();
    send_bits(24'h08_FFFF, 24);
    close_frame();
    chk(ok == 1'b1, "R6 bit19 dont care", ok, 1);

    // R1: reset mid-frame
    open_frame();
    send_bits(24'hC1_2345, 12);
    rst = 1;
    wt(2);
    chk(word == 0 && !valid && ok, "R1 reset mid frame", {word, valid, ok}, {24'h0, 2'b01});
    sel_n = 1;
    rst = 0;
    wt(6);
    p0 = pulses;
    open_frame();
    send_bits(24'h33_4455, 24);
    close_frame();
    chk(pulses == p0 + 1 && word == 24'h33_4455, "R2 frame after reset", word, 24'h334455);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule